// File: doc/BRIEF.md
# Reloadable Up/Down Timer and Event Counter Channel

This block is one counting channel with a reload register. In timer mode it advances once for each cycle in which the prescaled tick input is high. In event mode it advances on a selected edge of an external event input. The event input passes through a synchroniser and an edge detector first. The channel counts down or up. When the count wraps, it reloads from the reload register and sends out a one-cycle interrupt request. It can also toggle an output pin when the count wraps.

Software uses a small register port with a write strobe, a 2-bit address, write data and combinational read data. Address 0 is the control register. Bit 0 is the run flag and bit 1 enables cutoff. The control register can be written at any time. Address 1 is the mode register. Bit 0 selects event mode. Bit 1 selects counting up. Bit 2 selects the falling edge for events. Bit 3 enables the output pin. Bit 4 enables the interrupt. The mode register accepts writes only while the run flag is 0. Address 2 is the count register. Reading it returns the live count. Writing it loads the reload value. A write while stopped also loads the count. Address 3 reads as zero.

Every pin of the register port is a plain control pin with no handshake: there is no valid/ready and no back-pressure, and each access completes in the cycle it is presented. The pad is described by a drive-enable output and a data output. A low drive-enable means the pad is in high impedance. An active-low shutdown input, once synchronised, forces the drive-enable low while cutoff is enabled.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count is 0, the control and mode registers read 0, and irq_o is low. While the run flag (address 0, bit 0) is 0, the count does not change on ticks or events.
- R2: Writing address 2 while stopped loads both the count and the reload value. A following read of address 2 returns the written value.
- R3: In down mode (mode bit 1 = 0), each tick while running decrements the count. A step from 0 reloads the count. A read of address 2 in that step's cycle returns 16'hFFFF.
- R4: In up mode (mode bit 1 = 1), each tick while running increments the count. A step from 16'hFFFF reloads the count. A read of address 2 in that step's cycle returns 16'h0000.
- R5: Writing address 2 while running leaves the count stepping as before. The written value is used at the next reload, including a reload in the same cycle as the write.
- R6: Writes to the mode register (address 1) while running have no effect. Its readback is unchanged.
- R7: With mode bit 4 set, irq_o is high for exactly the one cycle after each reload step.
- R8: In event mode (mode bit 0 = 1), the tick input is ignored. An active edge on evt_i changes the count at the third rising clock edge after the edge. Mode bit 2 = 0 selects the rising edge and 1 selects the falling edge. The inactive edge has no effect.
- R9: With mode bit 3 set, pin_oe_o is high and pin_val_o (reset value 0) toggles on each reload step.
- R10: With control bit 1 set, shdn_n_i held low drives pin_oe_o low from the second rising edge on. pin_oe_o returns high two edges after shdn_n_i goes high again, or one edge after control bit 1 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data for addr |
| tick_i | input | 1 | Prescaled count tick for timer mode |
| evt_i | input | 1 | Asynchronous external event input |
| shdn_n_i | input | 1 | Asynchronous active-low shutdown input |
| irq_o | output | 1 | One-cycle interrupt request after a reload |
| pin_val_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Pad drive enable; low means high impedance |

## Verification
The bench builds the channel with its defaults: WIDTH = 16 and SYNC_STAGES = 2. Loading reload values close to 0 or to 16'hFFFF makes wraps happen every few ticks at both ends of the full 16-bit range. This means long random runs reach the collision reads many times, along with reloads that coincide with reload-register writes. With two synchroniser stages, the three-edge event latency and the two-edge cutoff latency are short enough to check cycle by cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADR_CTRL  = 2'd0;
  localparam logic [1:0] ADR_MODE  = 2'd1;
  localparam logic [1:0] ADR_COUNT = 2'd2;

  // bit 0 evt_mode ... bit 4 irq_en
  typedef struct packed {
    logic irq_en;
    logic out_en;
    logic fall_edge;
    logic count_up;
    logic evt_mode;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[0] <= RST_VAL;
        else        sh[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[g] <= RST_VAL;
        else        sh[g] <= sh[g-1];
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_evt_det.sv
module tmr_evt_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic fall_sel,
  output logic pulse_o
);
  logic lvl, prev;

  tmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(evt_i), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;

  assign pulse_o = fall_sel ? (prev & ~lvl) : (~prev & lvl);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             count_up,
  input  logic             step,
  input  logic             ld_en,
  input  logic [WIDTH-1:0] ld_val,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] reload_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] cnt_q, reload_q, reload_nxt;
  logic             adv;

  assign adv        = run & step;
  assign wrap_o     = adv & (count_up ? (&cnt_q) : ~(|cnt_q));
  assign reload_nxt = ld_en ? ld_val : reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else begin
      reload_q <= reload_nxt;
      if (ld_en && !run)   cnt_q <= ld_val;
      else if (wrap_o)     cnt_q <= reload_nxt;
      else if (adv)        cnt_q <= count_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic out_en,
  input  logic cut_en,
  input  logic shdn_sync_n,
  output logic pin_val_o,
  output logic pin_oe_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              lvl_q <= 1'b0;
    else if (wrap && out_en) lvl_q <= ~lvl_q;

  assign pin_val_o = lvl_q;
  assign pin_oe_o  = out_en & ~(cut_en & ~shdn_sync_n);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic             tick_i,
  input  logic             evt_i,
  input  logic             shdn_n_i,
  output logic             irq_o,
  output logic             pin_val_o,
  output logic             pin_oe_o
);
  logic             run_q, cut_en_q, irq_q;
  mode_t            mode_q;
  logic             wr_ctrl, wr_mode, wr_count;
  logic             evt_pulse, step_w, wrap_w, shdn_sync_n;
  logic [WIDTH-1:0] cnt_w, reload_w;

  assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
  assign wr_mode  = wr_en && (addr == ADR_MODE);
  assign wr_count = wr_en && (addr == ADR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cut_en_q <= 1'b0;
      mode_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q    <= wdata[0];
        cut_en_q <= wdata[1];
      end
      if (wr_mode && !run_q) mode_q <= mode_t'(wdata[MODE_W-1:0]);
      irq_q <= wrap_w & mode_q.irq_en;
    end
  end

  tmr_evt_det #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .fall_sel(mode_q.fall_edge), .pulse_o(evt_pulse)
  );

  assign step_w = mode_q.evt_mode ? evt_pulse : tick_i;

  tmr_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q), .count_up(mode_q.count_up),
    .step(step_w), .ld_en(wr_count), .ld_val(wdata),
    .cnt_o(cnt_w), .reload_o(reload_w), .wrap_o(wrap_w)
  );

  tmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_shdn (
    .clk(clk), .rst_n(rst_n), .d(shdn_n_i), .q(shdn_sync_n)
  );

  tmr_outpin u_pin (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .out_en(mode_q.out_en),
    .cut_en(cut_en_q), .shdn_sync_n(shdn_sync_n),
    .pin_val_o(pin_val_o), .pin_oe_o(pin_oe_o)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL:  rdata[1:0] = {cut_en_q, run_q};
      ADR_MODE:  rdata[MODE_W-1:0] = mode_q;
      ADR_COUNT: rdata = wrap_w ? {WIDTH{~mode_q.count_up}} : cnt_w;
      default:   rdata = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [WIDTH-1:0] wdata,
  input logic             shdn_n_i,
  input logic             pin_oe_o,
  input logic             irq_o,
  input logic             run_q,
  input logic             cut_en_q,
  input logic [4:0]       mode_q,
  input logic [WIDTH-1:0] cnt_w,
  input logic [WIDTH-1:0] reload_w,
  input logic             wrap_w
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  // R1
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && addr == 2'd2)) |=> $stable(cnt_w));

  // R2
  stopped_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && wr_en && addr == 2'd2) |=> (cnt_w == $past(wdata)));

  // R5
  running_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && addr == 2'd2) |=> (reload_w == $past(wdata)));

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && wr_en && addr == 2'd1) |=> $stable(mode_q));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(wrap_w));

  // R10
  cutoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && cut_en_q && !$past(shdn_n_i, 2)) |-> !pin_oe_o);
endmodule

bind tmr_chan tmr_chan_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .shdn_n_i(shdn_n_i), .pin_oe_o(pin_oe_o), .irq_o(irq_o),
  .run_q(run_q), .cut_en_q(cut_en_q), .mode_q(mode_q),
  .cnt_w(cnt_w), .reload_w(reload_w), .wrap_w(wrap_w)
);

// File: tb/test_tmr_chan.sv
`timescale 1ns/1ps
module test_tmr_chan;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, tick_i = 1'b0, evt_i = 1'b0, shdn_n_i = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  logic        irq_o, pin_val_o, pin_oe_o;

  int nchk = 0, nerr = 0;
  bit done = 0, ck = 1;

  logic [15:0] m_cnt = 0, m_rl = 0;
  logic [4:0]  m_mode = 0;
  bit          m_run = 0, m_cut = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  tmr_chan i_tmr_chan (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit f_wrap(bit tk);
    return m_run && tk && (m_mode[1] ? (m_cnt == 16'hFFFF) : (m_cnt == 16'h0000));
  endfunction

  function automatic logic [15:0] f_read(bit tk);
    if (f_wrap(tk)) return m_mode[1] ? 16'h0000 : 16'hFFFF;
    return m_cnt;
  endfunction

  // one cycle: drive, check before the edge, then advance the model
  task automatic cyc(bit we, logic [1:0] a, logic [15:0] d, bit tk, string tag);
    bit w;
    logic [15:0] rl_n;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; tick_i = tk;
    #1;
    if (ck) begin
      if (a == 2'd2) chk(tag, rdata, f_read(tk));
      if (a == 2'd1) chk("R6", rdata, {11'd0, m_mode});
      if (a == 2'd0) chk("R1", rdata, {14'd0, m_cut, m_run});
      chk("R7", irq_o, m_irq);
    end
    @(posedge clk);
    w    = f_wrap(tk);
    rl_n = (we && a == 2'd2) ? d : m_rl;
    if (we && a == 2'd2 && !m_run) m_cnt = d;
    else if (w)                    m_cnt = rl_n;
    else if (m_run && tk)          m_cnt = m_mode[1] ? m_cnt + 16'd1 : m_cnt - 16'd1;
    m_rl  = rl_n;
    m_irq = w && m_mode[4];
    if (we && a == 2'd1 && !m_run) m_mode = d[4:0];
    if (we && a == 2'd0) begin m_run = d[0]; m_cut = d[1]; end
  endtask

  task automatic rand_run(bit up, int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom % 100;
      bit tk = 1'($urandom % 2);
      string tg = up ? "R4" : "R3";
      if (r < 4)
        cyc(1, 2'd2, up ? 16'hFFFF - 16'($urandom % 12) : 16'($urandom % 12), tk, "R5");
      else if (r < 7)
        cyc(1, 2'd1, 16'($urandom), tk, "R6");
      else
        cyc(0, 2'($urandom % 3), 16'd0, tk, tg);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd7));
    #12 rst_n = 1'b1;
    // R1: reset state and no counting while stopped
    cyc(0, 2'd2, 0, 0, "R1");
    chk("R1", pin_oe_o, 1'b0);
    cyc(0, 2'd1, 0, 1, "R1");
    cyc(0, 2'd2, 0, 1, "R1");
    cyc(0, 2'd2, 0, 1, "R1");
    // R2: load while stopped
    cyc(1, 2'd2, 16'h1234, 0, "R2");
    cyc(0, 2'd2, 0, 1, "R2");
    // R3: down count through underflow
    cyc(1, 2'd1, 16'h0010, 0, "R3");
    cyc(1, 2'd2, 16'h0002, 0, "R3");
    cyc(1, 2'd0, 16'h0001, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(0, 2'd2, 0, 1, "R3");
    // R5: reload write while running
    cyc(1, 2'd2, 16'h0001, 1, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 2'd2, 0, 1, "R5");
    // R6: mode write while running ignored
    cyc(1, 2'd1, 16'h001F, 0, "R6");
    cyc(0, 2'd1, 0, 0, "R6");
    // R4: up count through overflow
    cyc(1, 2'd0, 16'h0000, 0, "R4");
    cyc(1, 2'd1, 16'h0012, 0, "R4");
    cyc(1, 2'd2, 16'hFFFE, 0, "R4");
    cyc(1, 2'd0, 16'h0001, 0, "R4");
    for (int i = 0; i < 5; i++) cyc(0, 2'd2, 0, 1, "R4");
    rand_run(1, 3000);
    cyc(1, 2'd0, 16'h0000, 0, "R3");
    cyc(1, 2'd1, 16'h0010, 0, "R3");
    cyc(1, 2'd2, 16'h0003, 0, "R3");
    cyc(1, 2'd0, 16'h0001, 0, "R3");
    rand_run(0, 3000);

    // R8: event mode, tick ignored
    ck = 0;
    cyc(1, 2'd0, 16'h0000, 0, "R8");
    cyc(1, 2'd1, 16'h0001, 0, "R8");
    cyc(1, 2'd2, 16'd10, 0, "R8");
    cyc(1, 2'd0, 16'h0001, 0, "R8");
    @(negedge clk); wr_en = 0; addr = 2'd2; tick_i = 1; evt_i = 1;
    idle(2); chk("R8", rdata, 16'd10);
    idle(1); chk("R8", rdata, 16'd9);
    evt_i = 0; idle(5); chk("R8", rdata, 16'd9);
    cyc(1, 2'd0, 16'h0000, 0, "R8");
    cyc(1, 2'd1, 16'h0005, 0, "R8");
    cyc(1, 2'd0, 16'h0001, 0, "R8");
    @(negedge clk); wr_en = 0; addr = 2'd2; evt_i = 1;
    idle(5); chk("R8", rdata, 16'd9);
    evt_i = 0; idle(2); chk("R8", rdata, 16'd9);
    idle(1); chk("R8", rdata, 16'd8);

    // R9: pin toggling
    cyc(1, 2'd0, 16'h0000, 0, "R9");
    cyc(1, 2'd1, 16'h0008, 0, "R9");
    cyc(1, 2'd2, 16'h0000, 0, "R9");
    cyc(1, 2'd0, 16'h0001, 0, "R9");
    @(negedge clk); wr_en = 0; #1;
    chk("R9", pin_oe_o, 1'b1); chk("R9", pin_val_o, 1'b0);
    tick_i = 1; idle(1); chk("R9", pin_val_o, 1'b1);
    idle(1); chk("R9", pin_val_o, 1'b0);
    tick_i = 0;
    // R10: cutoff
    shdn_n_i = 0; idle(2); chk("R10", pin_oe_o, 1'b1);
    cyc(1, 2'd0, 16'h0003, 0, "R10");
    @(negedge clk); wr_en = 0; #1; chk("R10", pin_oe_o, 1'b0);
    shdn_n_i = 1; idle(1); chk("R10", pin_oe_o, 1'b0);
    idle(1); chk("R10", pin_oe_o, 1'b1);
    shdn_n_i = 0; idle(2); chk("R10", pin_oe_o, 1'b0);
    cyc(1, 2'd0, 16'h0001, 0, "R10");
    @(negedge clk); wr_en = 0; #1; chk("R10", pin_oe_o, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog (R1..R10 run) actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule